// File: doc/BRIEF.md
# Exception Controller with Count/Compare Timer

This unit is the trap and privilege controller of a single-issue, five-stage 32-bit core. At the commit point the pipeline presents one instruction together with every fault flag gathered for it along the way. Those flags come from fetch, decode, execute and memory. The unit adds any pending interrupt to them. In the same cycle it picks the single event that wins under a fixed ranking and raises a pipeline flush with the fetch address to restart from. At the next clock edge it records the event in its control registers.

Software reaches the registers through a move interface. The interface carries a register number, a select, a write strobe and a combinational read port. A write changes state at the clock edge, so the following instruction already sees the new value and needs no hazard stall. The unit also contains a free-running counter that advances once every two clocks. A compare register turns it into a timer interrupt. A build parameter can remove user privilege altogether.

Top module: `exc_unit`

## Requirements
- R1: When `commitValid` is high and any request is present, `flush` goes high in the same cycle. The winner is chosen in this order: interrupt first, then `excReq` bit 0 (instruction address error), bit 1 (instruction TLB refill), bit 2 (instruction TLB invalid), bit 3 (coprocessor unusable), bit 4 (reserved instruction), bit 5 (overflow/trap/syscall/breakpoint group), bit 6 (data address error), bit 7 (data TLB refill), bit 8 (data TLB invalid), bit 9 (data TLB modified), bit 10 (return instruction). A lower bit always beats a higher one.
- R2: A taken exception writes its code to Cause[6:2]. The codes are:
  - interrupt: 0
  - instruction address error: 4
  - instruction TLB refill or invalid: 2
  - coprocessor unusable: 11
  - reserved instruction: 10
  - group: the value on `excGroupCode`
  - data address error: 5 if `excIsStore`, else 4
  - data TLB refill or invalid: 3 if `excIsStore`, else 2
  - data TLB modified: 1
- R3: A taken exception sets the exception level, Status[1]. If that level was clear beforehand, EPC (register 14/0) receives `excPc` and Cause[31] is cleared. When `excDelaySlot` is set, EPC instead receives `excPc`−4 and Cause[31] is set. If the level was already set, EPC and Cause[31] keep their values.
- R4: BadVAddr (register 8/0) is loaded only by address-error and TLB exceptions. Instruction-side faults load `excPc`. Data-side faults load `excDataAddr`. Every other event leaves BadVAddr unchanged.
- R5: An exception redirects to `VEC_BASE`+0x000 when it is a TLB refill and the exception level is clear. Every other exception redirects to `VEC_BASE`+0x180.
- R6: The return instruction redirects to ErrorEPC (register 30/0) and clears Status[2] when Status[2] is set. Otherwise it redirects to EPC and clears Status[1]. It changes neither Cause nor EPC.
- R7: Cause[15:8] shows the pending lines:
  - bit 15: the timer
  - bits 14:10: `extInt[4:0]`
  - bits 9:8: software bits written through Cause
  
  An interrupt is taken only when both of these hold:
  - Some bit of Cause[15:8] ANDed with the mask in Status[15:8] is set.
  - Status[0] is 1 while Status[1] and Status[2] are 0.
- R8: Count (register 9/0) advances by one every second clock. After a write of V, it reads V + floor(N/2) once N further clock edges have passed.
- R9: Compare (register 11/0) resets to 0xFFFFFFFF. Cause[15] becomes set once Count equals Compare. A write to Compare clears it.
- R10: After reset, Status reads 0x00000004 and Cause reads 0.
- R11: With `USER_MODE_EN`=1, `userMode` equals Status[4] AND NOT Status[1] AND NOT Status[2]. With `USER_MODE_EN`=0, Status[4] reads 0 and `userMode` stays 0.
- R12: A register write is visible on `cpRdData` in the next cycle. A write in a cycle with `flush` high is dropped. Register 16/0 reads `CONFIG0_VAL` and 16/1 reads `CONFIG1_VAL`. Unmapped numbers read 0.
- R13: With `commitValid` low, `flush` stays low and no request changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| commitValid | input | 1 | Instruction at the commit point is valid |
| excReq | input | 11 | Per-kind exception requests, priority order by bit |
| excPc | input | 32 | PC of the committing instruction |
| excDelaySlot | input | 1 | Instruction sits in a branch delay slot |
| excDataAddr | input | 32 | Virtual address of the data access |
| excIsStore | input | 1 | Data access is a store |
| excGroupCode | input | 5 | Code for the overflow/trap/syscall/breakpoint group |
| extInt | input | 5 | Hardware interrupt lines |
| cpRegNum | input | 5 | Register number for moves |
| cpRegSel | input | 3 | Register select for moves |
| cpWrEn | input | 1 | Move-to write strobe |
| cpWrData | input | 32 | Move-to data |
| cpRdData | output | 32 | Move-from data (combinational) |
| flush | output | 1 | Flush the pipeline and redirect fetch |
| redirectPc | output | 32 | Fetch restart address, valid with flush |
| userMode | output | 1 | Core runs with user privilege |

## Verification
The checker watches several properties on every cycle:
- Every qualified request produces a flush, and no flush appears without a committing instruction.
- The exception level is set after each trap, and a return with the error level set clears it.
- Every exception vector lands at offset 0x000 or 0x180.
- Count never moves by more than one per cycle unless written.
- User privilege never coexists with the exception or error level.

Other behaviour only the bench's scenarios can show:
- Which request wins among the 2047 request combinations.
- The exact code and the EPC, BD and BadVAddr contents.
- The Count value after a given number of edges.
- Timer matching and clearing.
- A write dropped under a flush.
- Behaviour with user mode built out.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_REQ = 11;
  localparam int NUM_EVT = NUM_REQ + 1;
  localparam int NUM_HW_INT = 5;

  typedef enum logic [3:0] {
    EV_INT, EV_IADDR, EV_ITLB_REFILL, EV_ITLB_INVALID, EV_COP_UNUSABLE,
    EV_RESERVED, EV_GROUP, EV_DADDR, EV_DTLB_REFILL, EV_DTLB_INVALID,
    EV_DTLB_MOD, EV_RETURN, EV_NONE
  } evt_e;

  typedef struct packed {
    logic       takeExc;
    logic       takeEret;
    logic [4:0] code;
    logic       loadBad;
    logic       badIsData;
    logic       refill;
  } strobe_t;

  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_MOD  = 5'd1;
  localparam logic [4:0] CODE_TLBL = 5'd2;
  localparam logic [4:0] CODE_TLBS = 5'd3;
  localparam logic [4:0] CODE_ADEL = 5'd4;
  localparam logic [4:0] CODE_ADES = 5'd5;
  localparam logic [4:0] CODE_RI   = 5'd10;
  localparam logic [4:0] CODE_CPU  = 5'd11;

  localparam logic [7:0] KEY_BADVADDR = {5'd8, 3'd0};
  localparam logic [7:0] KEY_COUNT    = {5'd9, 3'd0};
  localparam logic [7:0] KEY_COMPARE  = {5'd11, 3'd0};
  localparam logic [7:0] KEY_STATUS   = {5'd12, 3'd0};
  localparam logic [7:0] KEY_CAUSE    = {5'd13, 3'd0};
  localparam logic [7:0] KEY_EPC      = {5'd14, 3'd0};
  localparam logic [7:0] KEY_CONFIG0  = {5'd16, 3'd0};
  localparam logic [7:0] KEY_CONFIG1  = {5'd16, 3'd1};
  localparam logic [7:0] KEY_ERROREPC = {5'd30, 3'd0};
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic               commitValid,
  input  logic [NUM_REQ-1:0] excReq,
  input  logic               intPending,
  input  logic               isStore,
  input  logic [4:0]         groupCode,
  output strobe_t            strobe,
  output logic               flush
);
  logic [NUM_EVT-1:0] evtVec;
  evt_e winner;

  always_comb begin
    evtVec = commitValid ? {excReq, intPending} : '0;
    winner = EV_NONE;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (evtVec[i]) winner = evt_e'(4'(i));
    end
  end

  always_comb begin
    strobe = '0;
    strobe.takeExc = (winner != EV_NONE) && (winner != EV_RETURN);
    case (winner)
      EV_INT:          strobe.code = CODE_INT;
      EV_IADDR:        begin strobe.code = CODE_ADEL; strobe.loadBad = 1'b1; end
      EV_ITLB_REFILL:  begin strobe.code = CODE_TLBL; strobe.loadBad = 1'b1; strobe.refill = 1'b1; end
      EV_ITLB_INVALID: begin strobe.code = CODE_TLBL; strobe.loadBad = 1'b1; end
      EV_COP_UNUSABLE: strobe.code = CODE_CPU;
      EV_RESERVED:     strobe.code = CODE_RI;
      EV_GROUP:        strobe.code = groupCode;
      EV_DADDR: begin
        strobe.code = isStore ? CODE_ADES : CODE_ADEL;
        strobe.loadBad = 1'b1; strobe.badIsData = 1'b1;
      end
      EV_DTLB_REFILL: begin
        strobe.code = isStore ? CODE_TLBS : CODE_TLBL;
        strobe.loadBad = 1'b1; strobe.badIsData = 1'b1; strobe.refill = 1'b1;
      end
      EV_DTLB_INVALID: begin
        strobe.code = isStore ? CODE_TLBS : CODE_TLBL;
        strobe.loadBad = 1'b1; strobe.badIsData = 1'b1;
      end
      EV_DTLB_MOD: begin
        strobe.code = CODE_MOD;
        strobe.loadBad = 1'b1; strobe.badIsData = 1'b1;
      end
      EV_RETURN:       strobe.takeEret = 1'b1;
      default:         ;
    endcase
  end

  assign flush = strobe.takeExc | strobe.takeEret;
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE     = 32'h8000_0000,
  parameter bit          USER_MODE_EN = 1'b1,
  parameter logic [31:0] CONFIG0_VAL  = 32'h8000_0082,
  parameter logic [31:0] CONFIG1_VAL  = 32'h1E00_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [31:0]           excPc,
  input  logic                  excDelaySlot,
  input  logic [31:0]           excDataAddr,
  input  logic [NUM_HW_INT-1:0] extInt,
  input  logic [4:0]            regNum,
  input  logic [2:0]            regSel,
  input  logic                  wrEn,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic [31:0]           redirectPc,
  output logic                  userMode,
  output logic                  intPending,
  output logic                  statusExl,
  output logic                  statusErl,
  output logic [31:0]           countVal
);
  localparam logic [31:0] GENERAL_OFS = 32'h0000_0180;

  logic [31:0] countR, compareR, epc, badVAddr, errorEpc;
  logic        tick, timerPend, ie, exl, erl, um, bd;
  logic [7:0]  im, ipVec;
  logic [1:0]  ipSw;
  logic [4:0]  excCode;
  logic [7:0]  regKey;
  logic        wrOk;

  assign regKey = {regNum, regSel};
  assign wrOk   = wrEn && !(strobe.takeExc || strobe.takeEret);
  assign ipVec  = {timerPend, extInt, ipSw};

  assign intPending = (|(ipVec & im)) && ie && !exl && !erl;
  assign userMode   = USER_MODE_EN && um && !exl && !erl;
  assign statusExl  = exl;
  assign statusErl  = erl;
  assign countVal   = countR;

  always_comb begin
    if (strobe.takeEret) redirectPc = erl ? errorEpc : epc;
    else redirectPc = VEC_BASE + ((strobe.refill && !exl) ? 32'h0 : GENERAL_OFS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countR <= '0; compareR <= '1; tick <= 1'b0; timerPend <= 1'b0;
      ie <= 1'b0; exl <= 1'b0; erl <= 1'b1; um <= 1'b0; im <= '0;
      bd <= 1'b0; ipSw <= '0; excCode <= '0;
      epc <= '0; badVAddr <= '0; errorEpc <= '0;
    end else begin
      tick <= ~tick;
      if (tick) countR <= countR + 32'd1;
      if (countR == compareR) timerPend <= 1'b1;
      if (wrOk) begin
        case (regKey)
          KEY_COUNT:    begin countR <= wrData; tick <= 1'b0; end
          KEY_COMPARE:  begin compareR <= wrData; timerPend <= 1'b0; end
          KEY_STATUS: begin
            ie  <= wrData[0];
            exl <= wrData[1];
            erl <= wrData[2];
            um  <= USER_MODE_EN && wrData[4];
            im  <= wrData[15:8];
          end
          KEY_CAUSE:    ipSw <= wrData[9:8];
          KEY_EPC:      epc <= wrData;
          KEY_ERROREPC: errorEpc <= wrData;
          default:      ;
        endcase
      end
      if (strobe.takeExc) begin
        if (!exl) begin
          epc <= excDelaySlot ? excPc - 32'd4 : excPc;
          bd  <= excDelaySlot;
        end
        exl     <= 1'b1;
        excCode <= strobe.code;
        if (strobe.loadBad) badVAddr <= strobe.badIsData ? excDataAddr : excPc;
      end
      if (strobe.takeEret) begin
        if (erl) erl <= 1'b0;
        else exl <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (regKey)
      KEY_BADVADDR: rdData = badVAddr;
      KEY_COUNT:    rdData = countR;
      KEY_COMPARE:  rdData = compareR;
      KEY_STATUS:   rdData = {16'b0, im, 3'b0, um, 1'b0, erl, exl, ie};
      KEY_CAUSE:    rdData = {bd, 15'b0, ipVec, 1'b0, excCode, 2'b0};
      KEY_EPC:      rdData = epc;
      KEY_CONFIG0:  rdData = CONFIG0_VAL;
      KEY_CONFIG1:  rdData = CONFIG1_VAL;
      KEY_ERROREPC: rdData = errorEpc;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_BASE     = 32'h8000_0000,
  parameter bit          USER_MODE_EN = 1'b1,
  parameter logic [31:0] CONFIG0_VAL  = 32'h8000_0082,
  parameter logic [31:0] CONFIG1_VAL  = 32'h1E00_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        commitValid,
  input  logic [10:0] excReq,
  input  logic [31:0] excPc,
  input  logic        excDelaySlot,
  input  logic [31:0] excDataAddr,
  input  logic        excIsStore,
  input  logic [4:0]  excGroupCode,
  input  logic [4:0]  extInt,
  input  logic [4:0]  cpRegNum,
  input  logic [2:0]  cpRegSel,
  input  logic        cpWrEn,
  input  logic [31:0] cpWrData,
  output logic [31:0] cpRdData,
  output logic        flush,
  output logic [31:0] redirectPc,
  output logic        userMode
);
  strobe_t     strobe;
  logic        intPending, statusExl, statusErl;
  logic [31:0] countVal;

  exc_ctrl ctrl (
    .commitValid(commitValid), .excReq(excReq), .intPending(intPending),
    .isStore(excIsStore), .groupCode(excGroupCode),
    .strobe(strobe), .flush(flush)
  );

  exc_regs #(
    .VEC_BASE(VEC_BASE), .USER_MODE_EN(USER_MODE_EN),
    .CONFIG0_VAL(CONFIG0_VAL), .CONFIG1_VAL(CONFIG1_VAL)
  ) regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .excPc(excPc), .excDelaySlot(excDelaySlot), .excDataAddr(excDataAddr),
    .extInt(extInt), .regNum(cpRegNum), .regSel(cpRegSel),
    .wrEn(cpWrEn), .wrData(cpWrData), .rdData(cpRdData),
    .redirectPc(redirectPc), .userMode(userMode), .intPending(intPending),
    .statusExl(statusExl), .statusErl(statusErl), .countVal(countVal)
  );
endmodule

// File: rtl/exc_unit_check.sv
module exc_unit_check #(
  parameter logic [31:0] VEC_BASE = 32'h8000_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        commitValid,
  input logic [10:0] excReq,
  input logic        flush,
  input logic [31:0] redirectPc,
  input logic        userMode,
  input logic        takeExc,
  input logic        takeEret,
  input logic        exl,
  input logic        erl,
  input logic [31:0] countVal,
  input logic        cpWrEn
);
  assert_req_flushes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && (|excReq)) |-> flush);

  assert_flush_qualified_R13: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> commitValid);

  assert_exl_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && !cpWrEn) |=> exl);

  assert_vector_R5: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !takeEret) |->
      ((redirectPc - VEC_BASE) == 32'h0 || (redirectPc - VEC_BASE) == 32'h180));

  assert_return_erl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (takeEret && erl) |=> !erl);

  assert_user_kernel_R11: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> (!exl && !erl));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cpWrEn |=> (countVal == $past(countVal) || countVal == $past(countVal) + 32'd1));
endmodule

bind exc_unit exc_unit_check #(.VEC_BASE(VEC_BASE)) chk (
  .clk(clk), .rstN(rstN), .commitValid(commitValid), .excReq(excReq),
  .flush(flush), .redirectPc(redirectPc), .userMode(userMode),
  .takeExc(strobe.takeExc), .takeEret(strobe.takeEret),
  .exl(statusExl), .erl(statusErl), .countVal(countVal), .cpWrEn(cpWrEn)
);

// File: tb/exc_unit_test.sv
`timescale 1ns/1ps
module exc_unit_test;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        commitValid = 1'b0;
  logic [10:0] excReq = '0;
  logic [31:0] excPc = '0;
  logic        excDelaySlot = 1'b0;
  logic [31:0] excDataAddr = '0;
  logic        excIsStore = 1'b0;
  logic [4:0]  excGroupCode = '0;
  logic [4:0]  extInt = '0;
  logic [4:0]  cpRegNum = '0;
  logic [2:0]  cpRegSel = '0;
  logic        cpWrEn = 1'b0;
  logic [31:0] cpWrData = '0;
  logic [31:0] cpRdData, redirectPc, rdDataK, redirectK;
  logic        flush, userMode, flushK, userModeK;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  exc_unit uut (
    .clk(clk), .rstN(rstN), .commitValid(commitValid), .excReq(excReq),
    .excPc(excPc), .excDelaySlot(excDelaySlot), .excDataAddr(excDataAddr),
    .excIsStore(excIsStore), .excGroupCode(excGroupCode), .extInt(extInt),
    .cpRegNum(cpRegNum), .cpRegSel(cpRegSel), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .cpRdData(cpRdData), .flush(flush), .redirectPc(redirectPc), .userMode(userMode)
  );

  exc_unit #(.USER_MODE_EN(1'b0)) uutKernel (
    .clk(clk), .rstN(rstN), .commitValid(commitValid), .excReq(excReq),
    .excPc(excPc), .excDelaySlot(excDelaySlot), .excDataAddr(excDataAddr),
    .excIsStore(excIsStore), .excGroupCode(excGroupCode), .extInt(extInt),
    .cpRegNum(cpRegNum), .cpRegSel(cpRegSel), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .cpRdData(rdDataK), .flush(flushK), .redirectPc(redirectK), .userMode(userModeK)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cpRegNum = n; cpRegSel = s; cpWrData = d; cpWrEn = 1'b1;
    @(negedge clk);
    cpWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    cpRegNum = n; cpRegSel = s;
    #1 v = cpRdData;
  endtask

  task automatic peek(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    cpRegNum = n; cpRegSel = s;
    #1 v = cpRdData;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v, expEpc, expBad, expPc;
    logic [4:0]  expCode;
    logic        expBd;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state, R9 compare reset, R12 config reads
    rd(5'd12, 3'd0, v); check("R10 status after reset", v, 32'h4);
    rd(5'd13, 3'd0, v); check("R10 cause after reset", v, 32'h0);
    rd(5'd11, 3'd0, v); check("R9 compare reset value", v, 32'hFFFF_FFFF);
    rd(5'd16, 3'd0, v); check("R12 config0", v, 32'h8000_0082);
    rd(5'd16, 3'd1, v); check("R12 config1", v, 32'h1E00_0000);
    rd(5'd20, 3'd0, v); check("R12 unmapped reads zero", v, 32'h0);

    // R6 return with error level set
    wr(5'd30, 3'd0, 32'h1234_0000);
    wr(5'd14, 3'd0, 32'h0000_5550);
    @(negedge clk);
    commitValid = 1'b1; excReq = 11'h400;
    #1 check("R6 return uses ErrorEPC", {31'b0, flush}, 32'h1);
    check("R6 return redirect", redirectPc, 32'h1234_0000);
    @(negedge clk);
    commitValid = 1'b0; excReq = '0;
    peek(5'd12, 3'd0, v); check("R6 error level cleared", v, 32'h0);
    peek(5'd13, 3'd0, v); check("R6 cause untouched", v, 32'h0);

    // R8 count rate
    wr(5'd9, 3'd0, 32'd100);
    repeat (9) @(negedge clk);
    peek(5'd9, 3'd0, v); check("R8 count after 9 edges", v, 32'd104);
    @(negedge clk);
    peek(5'd9, 3'd0, v); check("R8 count after 10 edges", v, 32'd105);

    // R9 timer match and clear
    wr(5'd11, 3'd0, 32'd40);
    wr(5'd9, 3'd0, 32'd30);
    repeat (10) @(negedge clk);
    peek(5'd13, 3'd0, v); check("R9 no timer before match", {31'b0, v[15]}, 32'h0);
    repeat (20) @(negedge clk);
    peek(5'd13, 3'd0, v); check("R9 timer pending after match", {31'b0, v[15]}, 32'h1);

    // R7 timer interrupt taken
    wr(5'd12, 3'd0, 32'h0000_8001);
    @(negedge clk);
    commitValid = 1'b1; excPc = 32'h0000_2000;
    #1 check("R7 timer interrupt flush", {31'b0, flush}, 32'h1);
    check("R7 interrupt vector", redirectPc, BASE + 32'h180);
    @(negedge clk);
    commitValid = 1'b0;
    peek(5'd13, 3'd0, v); check("R2 interrupt code", {27'b0, v[6:2]}, 32'h0);
    wr(5'd11, 3'd0, 32'hFFFF_0000);
    peek(5'd13, 3'd0, v); check("R9 compare write clears timer", {31'b0, v[15]}, 32'h0);

    // R7 external interrupt beats instruction address error; gated by EXL
    wr(5'd12, 3'd0, 32'h0);
    extInt = 5'b00001;
    wr(5'd12, 3'd0, 32'h0000_0401);
    peek(5'd13, 3'd0, v); check("R7 ext line in cause bit 10", {31'b0, v[10]}, 32'h1);
    @(negedge clk);
    commitValid = 1'b1; excReq = 11'h001; excPc = 32'h0000_3000;
    #1 check("R1 interrupt flush", {31'b0, flush}, 32'h1);
    @(negedge clk);
    excReq = '0;
    #1 check("R7 masked while exception level set", {31'b0, flush}, 32'h0);
    commitValid = 1'b0;
    peek(5'd13, 3'd0, v); check("R1 interrupt outranks address error", {27'b0, v[6:2]}, 32'h0);
    extInt = '0;

    // R1 R2 R3 R4 R5 R6 sweep of all request combinations
    expBad = 32'h0;
    peek(5'd14, 3'd0, v); expEpc = v;
    peek(5'd13, 3'd0, v); expCode = v[6:2]; expBd = v[31];
    for (int mask = 1; mask < 2048; mask++) begin
      int win;
      logic ld, dat, refl, st;
      wr(5'd12, 3'd0, 32'h0);
      @(negedge clk);
      win = 0;
      for (int b = 10; b >= 0; b--) if (mask[b]) win = b;
      st = mask[2] ^ mask[5];
      commitValid = 1'b1; excReq = mask[10:0];
      excPc = 32'h0040_0000 + mask * 8;
      excDelaySlot = mask[1];
      excDataAddr = 32'h1000_0000 ^ (mask << 3);
      excIsStore = st;
      excGroupCode = 5'd12 + {4'b0, mask[4]};
      ld = 1'b0; dat = 1'b0; refl = 1'b0;
      case (win)
        0: begin expCode = 5'd4; ld = 1'b1; end
        1: begin expCode = 5'd2; ld = 1'b1; refl = 1'b1; end
        2: begin expCode = 5'd2; ld = 1'b1; end
        3: expCode = 5'd11;
        4: expCode = 5'd10;
        5: expCode = 5'd12 + {4'b0, mask[4]};
        6: begin expCode = st ? 5'd5 : 5'd4; ld = 1'b1; dat = 1'b1; end
        7: begin expCode = st ? 5'd3 : 5'd2; ld = 1'b1; dat = 1'b1; refl = 1'b1; end
        8: begin expCode = st ? 5'd3 : 5'd2; ld = 1'b1; dat = 1'b1; end
        9: begin expCode = 5'd1; ld = 1'b1; dat = 1'b1; end
        default: ;
      endcase
      if (win == 10) expPc = expEpc;
      else expPc = BASE + (refl ? 32'h0 : 32'h180);
      #1 check("R1 sweep flush", {31'b0, flush}, 32'h1);
      check("R5 R6 sweep redirect", redirectPc, expPc);
      if (win != 10) begin
        expEpc = mask[1] ? excPc - 32'd4 : excPc;
        expBd = mask[1];
        if (ld) expBad = dat ? excDataAddr : excPc;
      end
      @(negedge clk);
      commitValid = 1'b0; excReq = '0;
      peek(5'd13, 3'd0, v);
      check("R2 sweep code", {27'b0, v[6:2]}, {27'b0, expCode});
      check("R3 sweep delay-slot flag", {31'b0, v[31]}, {31'b0, expBd});
      peek(5'd14, 3'd0, v); check("R3 sweep EPC", v, expEpc);
      peek(5'd8, 3'd0, v);  check("R4 sweep BadVAddr", v, expBad);
    end

    // R3 nested exception keeps EPC; R5 refill with EXL set uses 0x180
    wr(5'd12, 3'd0, 32'h0);
    @(negedge clk);
    commitValid = 1'b1; excReq = 11'h010; excPc = 32'h0000_7000; excDelaySlot = 1'b0;
    @(negedge clk);
    excReq = 11'h002; excPc = 32'h0000_9000; excDelaySlot = 1'b1;
    #1 check("R5 refill with EXL set", redirectPc, BASE + 32'h180);
    @(negedge clk);
    commitValid = 1'b0; excReq = '0; excDelaySlot = 1'b0;
    peek(5'd14, 3'd0, v); check("R3 nested EPC kept", v, 32'h0000_7000);
    peek(5'd13, 3'd0, v); check("R3 nested BD kept", {31'b0, v[31]}, 32'h0);

    // R12 write dropped under flush
    wr(5'd12, 3'd0, 32'h0);
    @(negedge clk);
    commitValid = 1'b1; excReq = 11'h008; excPc = 32'h0000_A000;
    cpRegNum = 5'd14; cpRegSel = 3'd0; cpWrData = 32'hDEAD_0000; cpWrEn = 1'b1;
    @(negedge clk);
    commitValid = 1'b0; excReq = '0; cpWrEn = 1'b0;
    peek(5'd14, 3'd0, v); check("R12 write dropped during flush", v, 32'h0000_A000);

    // R13 no commit, no effect
    wr(5'd12, 3'd0, 32'h0);
    @(negedge clk);
    excReq = 11'h001; excPc = 32'h0000_B000;
    #1 check("R13 no flush without commit", {31'b0, flush}, 32'h0);
    @(negedge clk);
    excReq = '0;
    peek(5'd14, 3'd0, v); check("R13 EPC unchanged", v, 32'h0000_A000);
    peek(5'd12, 3'd0, v); check("R13 status unchanged", v, 32'h0);

    // R11 user mode and its build-time removal
    wr(5'd12, 3'd0, 32'h0000_0010);
    #1 check("R11 user mode on", {31'b0, userMode}, 32'h1);
    check("R11 kernel-only build stays kernel", {31'b0, userModeK}, 32'h0);
    check("R11 kernel-only build UM reads 0", {31'b0, rdDataK[4]}, 32'h0);
    wr(5'd12, 3'd0, 32'h0000_0012);
    #1 check("R11 user mode off under EXL", {31'b0, userMode}, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule